// File: doc/BRIEF.md
# Receive Line Idle Timeout Detector

This block watches a serial receiver for a quiet line. It counts down a programmed number of bit periods after the last received character. When the count runs out it raises a sticky status flag, which software can read as the end of a variable-length frame. A bit-period tick from the baud generator drives the count, not the system clock. Each received character starts the full period again.

Software picks one of two restart modes after a timeout. The arm command clears the flag and freezes the counter until the next character arrives, so a long silence between frames raises nothing. In this mode the block detects end-of-frame. The restart command clears the flag, reloads the counter and starts counting at once. Issued after every expiry, it gives a periodic no-input timer. A programmed value of zero turns the block off. An interrupt request is the flag gated by an enable input.

The controller has four states:
- `ST_OFF`: the timeout value is zero.
- `ST_WAIT`: frozen, waiting for a character.
- `ST_RUN`: counting.
- `ST_DONE`: expired and stopped.

Transitions:
- Any state goes to OFF when the value is zero.
- OFF goes to WAIT when the value becomes nonzero.
- Any state goes to RUN on a restart command or a character.
- Any state goes to WAIT on an arm command.
- RUN goes to DONE on the tick that takes the counter from 1 to 0.

Top module: `rx_idle_timeout`

## Requirements
- R1: After reset the flag and the interrupt are low and the block is in WAIT. Bit ticks alone never raise the flag until a character or a restart command arrives.
- R2: While `to_value` is zero, the flag is low from the next cycle on and stays low, whatever characters, ticks or commands arrive.
- R3: With a nonzero value N, a character loads the counter with N. The flag rises at the clock edge that samples the Nth following bit tick.
- R4: The counter changes only on cycles where `bit_tick` is high. Cycles without a tick leave the remaining time unchanged.
- R5: A character that arrives while the counter is running restarts the full period of N ticks.
- R6: When a character and a bit tick come in the same cycle, the reload wins and that tick is not counted.
- R7: When the counter reaches zero it stops without wrapping. The flag stays high until an arm or restart command.
- R8: The arm command (`cmd_arm`) clears the flag at the next edge. It also freezes the counter, so no timeout is raised until a character has arrived and N ticks have followed it.
- R9: The restart command (`cmd_restart`) clears the flag and reloads N at the next edge. Counting starts with no character needed, so N ticks later the flag rises again.
- R10: `irq` is high exactly when the flag is high and `irq_en` is high.
- R11: The counter is 16 bits wide. A value of 65535 raises the flag on the 65535th tick and not before.
- R12: Priority in one cycle: a zero value first, then restart, then character, then arm.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_tick | input | 1 | One-cycle pulse per bit period |
| char_rx | input | 1 | One-cycle pulse per received character |
| to_value | input | 16 | Programmed timeout in bit periods; 0 disables |
| cmd_arm | input | 1 | Clear flag, wait for next character |
| cmd_restart | input | 1 | Clear flag, reload and count at once |
| irq_en | input | 1 | Interrupt enable |
| to_flag | output | 1 | Sticky timeout status |
| irq | output | 1 | Interrupt request |

## Verification
Every registered result is due one edge after its cause:
- The flag rises at the edge that samples the expiring tick.
- The flag clears at the edge that samples a command.
- The flag clears at the edge after a zero value is seen.

`irq` follows the flag and `irq_en` in the same cycle. The bench drives inputs on the falling edge and holds them across one rising edge. It samples on the following falling edge, so each check sees exactly one rising edge's effect. A cycle-level reference model, built from the requirements, advances on the same rising edges and is compared on every falling edge.

// File: rtl/rx_idle_timeout_pkg.sv
package rx_idle_timeout_pkg;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_WAIT = 2'd1,
        ST_RUN  = 2'd2,
        ST_DONE = 2'd3
    } rxto_state_e;

endpackage

// File: rtl/rxto_ctrl.sv
module rxto_ctrl
    import rx_idle_timeout_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        val_zero,
    input  logic        bit_tick,
    input  logic        char_rx,
    input  logic        cmd_arm,
    input  logic        cmd_restart,
    input  logic        cnt_last,
    output rxto_state_e state,
    output logic        load,
    output logic        dec,
    output logic        expire
);

    rxto_state_e state_q;
    rxto_state_e state_d;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_WAIT;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state selection, priority: zero, restart, char, arm
    always_comb begin
        state_d = state_q;
        if (val_zero) begin
            state_d = ST_OFF;
        end else if (cmd_restart || char_rx) begin
            state_d = ST_RUN;
        end else if (cmd_arm) begin
            state_d = ST_WAIT;
        end else begin
            unique case (state_q)
                ST_OFF:  state_d = ST_WAIT;
                ST_WAIT: state_d = ST_WAIT;
                ST_RUN:  state_d = (bit_tick && cnt_last) ? ST_DONE : ST_RUN;
                ST_DONE: state_d = ST_DONE;
                default: state_d = ST_WAIT;
            endcase
        end
    end

    // Output decode
    always_comb begin
        load   = 1'b0;
        dec    = 1'b0;
        expire = 1'b0;
        if (!val_zero) begin
            if (cmd_restart || char_rx) begin
                load = 1'b1;
            end else if (!cmd_arm) begin
                unique case (state_q)
                    ST_RUN: begin
                        dec    = bit_tick;
                        expire = bit_tick && cnt_last;
                    end
                    ST_OFF, ST_WAIT, ST_DONE: begin
                        dec = 1'b0;
                    end
                    default: dec = 1'b0;
                endcase
            end
        end
    end

    assign state = state_q;

    AST_NO_DEC_WITHOUT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        dec |-> bit_tick); // R4
    AST_CHAR_BEATS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (char_rx && !val_zero) |-> (load && !dec)); // R6
    AST_ZERO_GOES_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        val_zero |=> (state_q == ST_OFF)); // R2
    AST_RESTART_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_restart && !val_zero) |=> (state_q == ST_RUN)); // R9
    AST_ARM_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_arm && !cmd_restart && !char_rx && !val_zero) |=> (state_q == ST_WAIT)); // R8

endmodule

// File: rtl/rxto_counter.sv
module rxto_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             dec,
    input  logic [CNT_W-1:0] value,
    output logic [CNT_W-1:0] count,
    output logic             last
);

    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= value;
        end else if (dec && (cnt_q != '0)) begin
            cnt_q <= cnt_q - ONE;
        end
    end

    assign count = cnt_q;
    assign last  = (cnt_q == ONE);

    AST_LOAD_TAKES_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt_q == $past(value))); // R3
    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !dec) |=> $stable(cnt_q)); // R4
    AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt_q == '0) |=> (cnt_q == '0)); // R7

endmodule

// File: rtl/rxto_flag.sv
module rxto_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    input  logic irq_en,
    output logic flag,
    output logic irq
);

    logic flag_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (clr) begin
            flag_q <= 1'b0;
        end else if (set) begin
            flag_q <= 1'b1;
        end
    end

    assign flag = flag_q;
    assign irq  = flag_q & irq_en;

    AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !flag_q); // R8
    AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !clr) |=> flag_q); // R7

endmodule

// File: rtl/rx_idle_timeout.sv
module rx_idle_timeout
    import rx_idle_timeout_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_tick,
    input  logic             char_rx,
    input  logic [CNT_W-1:0] to_value,
    input  logic             cmd_arm,
    input  logic             cmd_restart,
    input  logic             irq_en,
    output logic             to_flag,
    output logic             irq
);

    rxto_state_e      state;
    logic             load;
    logic             dec;
    logic             expire;
    logic             cnt_last;
    logic [CNT_W-1:0] count;
    logic             val_zero;
    logic             flag_clr;

    assign val_zero = (to_value == '0);
    assign flag_clr = cmd_arm | cmd_restart | val_zero;

    rxto_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .val_zero    (val_zero),
        .bit_tick    (bit_tick),
        .char_rx     (char_rx),
        .cmd_arm     (cmd_arm),
        .cmd_restart (cmd_restart),
        .cnt_last    (cnt_last),
        .state       (state),
        .load        (load),
        .dec         (dec),
        .expire      (expire)
    );

    rxto_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .dec   (dec),
        .value (to_value),
        .count (count),
        .last  (cnt_last)
    );

    rxto_flag u_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .set    (expire),
        .clr    (flag_clr),
        .irq_en (irq_en),
        .flag   (to_flag),
        .irq    (irq)
    );

    AST_ZERO_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        val_zero |=> !to_flag); // R2
    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (to_flag && irq_en)); // R10
    AST_DONE_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DONE) |-> (count == '0)); // R7
    AST_RISE_ONLY_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(to_flag) |-> ($past(state) == ST_RUN)); // R3

endmodule

// File: tb/rx_idle_timeout_tb.sv
module rx_idle_timeout_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 190000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_tick = 1'b0;
    logic        char_rx = 1'b0;
    logic [15:0] to_value = 16'd3;
    logic        cmd_arm = 1'b0;
    logic        cmd_restart = 1'b0;
    logic        irq_en = 1'b1;
    logic        to_flag;
    logic        irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rx_idle_timeout u_dut (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .char_rx(char_rx),
        .to_value(to_value), .cmd_arm(cmd_arm), .cmd_restart(cmd_restart),
        .irq_en(irq_en), .to_flag(to_flag), .irq(irq)
    );

    // Reference model built from R1..R12
    int   m_cnt;
    bit   m_run;
    bit   m_flag;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt  <= 0;
            m_run  <= 1'b0;
            m_flag <= 1'b0;
        end else if (to_value == 16'd0) begin
            m_run  <= 1'b0;
            m_flag <= 1'b0;
        end else if (cmd_restart || char_rx) begin
            m_cnt  <= int'(to_value);
            m_run  <= 1'b1;
            if (cmd_restart || cmd_arm) m_flag <= 1'b0;
        end else if (cmd_arm) begin
            m_run  <= 1'b0;
            m_flag <= 1'b0;
        end else if (m_run && bit_tick) begin
            m_cnt <= m_cnt - 1;
            if (m_cnt == 1) begin
                m_run  <= 1'b0;
                m_flag <= 1'b1;
            end
        end
    end

    function automatic bit exp_irq(bit f, bit en);
        return f & en;
    endfunction

    task automatic check(input bit act, input bit exp, input string tag);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0b expected=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model (R3, R7, R10)
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(to_flag, m_flag, "R7 model flag");
            check(irq, exp_irq(m_flag, irq_en), "R10 model irq");
        end
    end

    task automatic cyc(input bit c, input bit t, input bit a, input bit r);
        char_rx = c; bit_tick = t; cmd_arm = a; cmd_restart = r;
        @(negedge clk);
        char_rx = 1'b0; bit_tick = 1'b0; cmd_arm = 1'b0; cmd_restart = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) cyc(1'b0, 1'b1, 1'b0, 1'b0);
    endtask

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        int unsigned seed;
        seed = 32'd1234;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state, ticks alone do nothing
        check(to_flag, 1'b0, "R1 reset flag");
        check(irq, 1'b0, "R1 reset irq");
        ticks(10);
        check(to_flag, 1'b0, "R1 ticks before char");

        // R3: char then N=3 ticks
        cyc(1, 0, 0, 0);
        ticks(2);
        check(to_flag, 1'b0, "R3 before Nth tick");
        ticks(1);
        check(to_flag, 1'b1, "R3 at Nth tick");
        check(irq, 1'b1, "R10 irq enabled");
        ticks(5);
        check(to_flag, 1'b1, "R7 sticky no wrap");
        irq_en = 1'b0;
        #1;
        check(irq, 1'b0, "R10 irq masked");
        irq_en = 1'b1;

        // R8: arm clears and freezes
        cyc(0, 0, 1, 0);
        check(to_flag, 1'b0, "R8 arm clears");
        ticks(10);
        check(to_flag, 1'b0, "R8 frozen while idle");
        // R6: char with tick, reload wins
        cyc(1, 1, 0, 0);
        ticks(2);
        check(to_flag, 1'b0, "R6 tick not counted");
        ticks(1);
        check(to_flag, 1'b1, "R6 expires after N more");

        // R9: restart, periodic
        cyc(0, 0, 0, 1);
        check(to_flag, 1'b0, "R9 restart clears");
        ticks(3);
        check(to_flag, 1'b1, "R9 first period");
        cyc(0, 0, 0, 1);
        ticks(2);
        check(to_flag, 1'b0, "R9 second period early");
        ticks(1);
        check(to_flag, 1'b1, "R9 second period");

        // R4: no ticks, no progress
        cyc(0, 0, 0, 1);
        repeat (20) cyc(0, 0, 0, 0);
        check(to_flag, 1'b0, "R4 no tick no count");
        ticks(3);
        check(to_flag, 1'b1, "R4 counts on ticks");

        // R5: char mid-count restarts full period
        cyc(0, 0, 1, 0);
        cyc(1, 0, 0, 0);
        ticks(2);
        cyc(1, 0, 0, 0);
        ticks(2);
        check(to_flag, 1'b0, "R5 reload extends");
        ticks(1);
        check(to_flag, 1'b1, "R5 full period");

        // R12: restart+char+arm together -> run
        cyc(1, 0, 1, 1);
        check(to_flag, 1'b0, "R12 flag cleared");
        ticks(3);
        check(to_flag, 1'b1, "R12 restart wins");
        cyc(1, 0, 1, 0);
        check(to_flag, 1'b0, "R12 arm clears with char");
        ticks(3);
        check(to_flag, 1'b1, "R12 char beats arm");

        // R2: zero value disables
        to_value = 16'd0;
        @(negedge clk);
        check(to_flag, 1'b0, "R2 zero clears flag");
        cyc(1, 0, 0, 0);
        ticks(10);
        check(to_flag, 1'b0, "R2 char ignored");
        cyc(0, 0, 0, 1);
        ticks(10);
        check(to_flag, 1'b0, "R2 restart ignored");

        // R11: maximum value
        to_value = 16'hFFFF;
        @(negedge clk);
        cyc(1, 0, 0, 0);
        ticks(65534);
        check(to_flag, 1'b0, "R11 one tick short");
        ticks(1);
        check(to_flag, 1'b1, "R11 max expires");

        // Random phase, checked by the model
        cyc(0, 0, 1, 0);
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(0, 49) == 0) to_value = 16'($urandom_range(0, 6));
            irq_en = 1'($urandom_range(0, 1));
            cyc(($urandom_range(0, 9) == 0), ($urandom_range(0, 1) == 1),
                ($urandom_range(0, 29) == 0), ($urandom_range(0, 29) == 0));
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule